// File: doc/BRIEF.md
# Receive DMA Word Packer

This block sits between a MAC receive byte FIFO and a memory write port. It pops received bytes one at a time and gathers them into 32-bit words. Each word goes out on a valid/ready handshake with a byte-valid count and a frame-end flag. The first word of every frame begins with a programmable number of zero pad lanes. A configuration option reverses the byte order of every word as it leaves. The block also keeps the index of the current receive descriptor, which steps around a power-of-two ring.

A single 32-bit control word sets the ring length, the pad count and the swap option, and holds the run bit and the self-clearing clear bit. A descriptor ownership result arrives from outside. If the current descriptor is not owned by the DMA, the run bit drops. Bytes already waiting in the FIFO are still packed until the FIFO reads empty. Descriptor fetch, bus arbitration and status write-back belong to neighbouring logic.

Top module: `rxdma_packer`

## Requirements
- R1: Ring code k in bits [3:0] gives a ring of 2^k descriptors for k below 12, and 4096 for k of 12 to 15. `desc_idx` steps by one when the last byte of a frame is popped and goes to 0 after ring size minus 1. It changes at no other time except on clear.
- R2: The pad field in bits [5:4] gives 0 to 3 pad lanes. The first byte of every frame lands in that lane (lane 0 = bits 7:0), and the lanes below it are written as zero.
- R3: Frame bytes fill lanes in ascending order. A word is emitted as soon as lane 3 is filled.
- R4: When the last byte of a frame is packed, the word is emitted at once with `mem_last` = 1. Its unused upper lanes are zero and `mem_bytes` = highest filled lane + 1, so 1 to 4.
- R5: With the swap bit (bit 8) set, an assembled word with bytes (B3,B2,B1,B0) is written as (B0,B1,B2,B3). With it clear, the word is written unchanged.
- R6: With the run bit (bit 12) at 0 and no drain pending, no byte is popped.
- R7: `own_chk` = 1 with `own_by_dma` = 0 clears the run bit at the next edge, and this overrides a same-cycle write. `own_chk` with `own_by_dma` = 1 leaves the run bit unchanged.
- R8: After the run bit falls, popping continues until the FIFO reads empty. After that, bytes entering the FIFO stay unpopped until run is set again.
- R9: Writing 1 to the clear bit (bit 16) makes it read 1 for one cycle. At the following edge every field reads 0, `desc_idx` is 0, any partial or pending word is discarded and the next byte starts a new frame. Reset gives the same all-zero state.
- R10: While `mem_valid` = 1 and `mem_ready` = 0, the output word, count and flag hold steady and no byte is popped.
- R11: Bits other than [3:0], [5:4], 8, 12 and 16 read 0 whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| own_chk | input | 1 | Ownership result of the current descriptor is valid |
| own_by_dma | input | 1 | Current descriptor is owned by the DMA |
| fifo_empty | input | 1 | Receive FIFO has no byte |
| fifo_byte | input | 8 | Byte at the FIFO head |
| fifo_last | input | 1 | Head byte is the last of its frame |
| fifo_pop | output | 1 | Take the head byte this cycle |
| mem_valid | output | 1 | Output word is valid |
| mem_ready | input | 1 | Memory side accepts the word |
| mem_data | output | 32 | Packed word |
| mem_bytes | output | 3 | Filled lanes in the word, 1 to 4 |
| mem_last | output | 1 | Word ends a frame |
| desc_idx | output | 12 | Current descriptor index |

## Verification
The hardest state to reach from the ports is the drain window. The run bit must already have been dropped by a failed ownership check while bytes are still queued, and the FIFO must then refill after it has run dry. The bench reaches it by holding `mem_ready` low so that a backlog of two frames builds up. It then pulses the ownership failure, releases the memory side, and checks that the whole backlog drains. A later frame pushed into the FIFO must then sit untouched. A clear issued while a frame is half packed is the other awkward case. The bench feeds bytes without a frame end so that the packer holds a partial word at the moment of the clear.

// File: rtl/rxdma_pkg.sv
`timescale 1ns/1ps
package rxdma_pkg;
   localparam int CFG_W       = 32;
   localparam int RING_CODE_W = 4;
   localparam int PAD_W       = 2;
   localparam int RING_LSB    = 0;
   localparam int PAD_LSB     = 4;
   localparam int SWAP_BIT    = 8;
   localparam int RUN_BIT     = 12;
   localparam int CLR_BIT     = 16;

   typedef struct packed {
      logic [RING_CODE_W-1:0] ring_code;
      logic [PAD_W-1:0]       pad;
      logic                   swap;
      logic                   run;
   } rx_cfg_t;
endpackage

// File: rtl/rxdma_ctrl_reg.sv
`timescale 1ns/1ps
module rxdma_ctrl_reg
   import rxdma_pkg::*;
#(
   parameter bit SWAP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wdata,
   input  logic             own_fail,
   input  logic             fifo_empty,
   output rx_cfg_t          cfg,
   output logic             clr_active,
   output logic             xfer_en,
   output logic [CFG_W-1:0] rdata
);
   rx_cfg_t cfg_q, cfg_nxt;
   logic    clr_q, clr_nxt;
   logic    drain_q;
   logic    swap_wr;
   logic    unused_wdata;

   assign unused_wdata = ^wdata;

   generate
      if (SWAP_EN) begin : g_swap_on
         assign swap_wr = wdata[SWAP_BIT];
      end else begin : g_swap_off
         assign swap_wr = 1'b0;
      end
   endgenerate

   always_comb begin
      cfg_nxt = cfg_q;
      clr_nxt = 1'b0;
      if (wr_en) begin
         cfg_nxt.ring_code = wdata[RING_LSB +: RING_CODE_W];
         cfg_nxt.pad       = wdata[PAD_LSB +: PAD_W];
         cfg_nxt.swap      = swap_wr;
         cfg_nxt.run       = wdata[RUN_BIT];
         clr_nxt           = wdata[CLR_BIT];
      end
      if (own_fail) begin
         cfg_nxt.run = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         clr_q   <= 1'b0;
         drain_q <= 1'b0;
      end else if (clr_q) begin
         cfg_q   <= '0;
         clr_q   <= 1'b0;
         drain_q <= 1'b0;
      end else begin
         cfg_q <= cfg_nxt;
         clr_q <= clr_nxt;
         if (cfg_q.run && !cfg_nxt.run) begin
            drain_q <= 1'b1;
         end else if (fifo_empty) begin
            drain_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata                             = '0;
      rdata[RING_LSB +: RING_CODE_W]    = cfg_q.ring_code;
      rdata[PAD_LSB +: PAD_W]           = cfg_q.pad;
      rdata[SWAP_BIT]                   = cfg_q.swap;
      rdata[RUN_BIT]                    = cfg_q.run;
      rdata[CLR_BIT]                    = clr_q;
   end

   assign cfg        = cfg_q;
   assign clr_active = clr_q;
   assign xfer_en    = (cfg_q.run || drain_q) && !clr_q;
endmodule

// File: rtl/rxdma_ring_index.sv
`timescale 1ns/1ps
module rxdma_ring_index #(
   parameter int IDX_W  = 12,
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic [CODE_W-1:0] code,
   input  logic              advance,
   output logic [IDX_W-1:0]  idx
);
   generate
      if (IDX_W >= (1 << CODE_W)) begin : g_bad_code
         $error("rxdma_ring_index: ring code cannot reach IDX_W bits");
      end
   endgenerate

   logic [IDX_W-1:0] mask;
   logic [IDX_W-1:0] idx_q;

   always_comb begin
      mask = '0;
      for (int i = 0; i < IDX_W; i++) begin
         if (i < int'(code)) mask[i] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (soft_clr) begin
         idx_q <= '0;
      end else if (advance) begin
         idx_q <= (idx_q + 1'b1) & mask;
      end
   end

   assign idx = idx_q;
endmodule

// File: rtl/rxdma_byte_packer.sv
`timescale 1ns/1ps
module rxdma_byte_packer #(
   parameter int BYTE_W  = 8,
   parameter int LANES   = 4,
   parameter bit SWAP_EN = 1'b1,
   localparam int WORD_W = BYTE_W * LANES,
   localparam int LANE_W = $clog2(LANES),
   localparam int CNT_W  = $clog2(LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              xfer_en,
   input  logic [LANE_W-1:0] pad,
   input  logic              swap,
   input  logic              fifo_empty,
   input  logic [BYTE_W-1:0] fifo_byte,
   input  logic              fifo_last,
   output logic              fifo_pop,
   output logic              frame_done,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word,
   output logic [CNT_W-1:0]  out_bytes,
   output logic              out_last
);
   logic [WORD_W-1:0] acc_q, acc_nxt, rev_word, word_fmt;
   logic [LANE_W-1:0] lane_q, lane_sel;
   logic              start_q;
   logic              slot_free, emit;

   assign slot_free  = !out_valid || out_ready;
   assign fifo_pop   = xfer_en && !fifo_empty && slot_free;
   assign lane_sel   = start_q ? pad : lane_q;
   assign emit       = fifo_pop && (fifo_last || (lane_sel == LANE_W'(LANES - 1)));
   assign frame_done = fifo_pop && fifo_last;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign acc_nxt[g*BYTE_W +: BYTE_W] =
            (lane_sel == LANE_W'(g)) ? fifo_byte : acc_q[g*BYTE_W +: BYTE_W];
         assign rev_word[g*BYTE_W +: BYTE_W] = acc_nxt[(LANES-1-g)*BYTE_W +: BYTE_W];
      end
      if (SWAP_EN) begin : g_swap_on
         assign word_fmt = swap ? rev_word : acc_nxt;
      end else begin : g_swap_off
         logic unused_swap;
         assign unused_swap = swap ^ (^rev_word);
         assign word_fmt    = acc_nxt;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || soft_clr) begin
         acc_q     <= '0;
         lane_q    <= '0;
         start_q   <= 1'b1;
         out_valid <= 1'b0;
         out_word  <= '0;
         out_bytes <= '0;
         out_last  <= 1'b0;
      end else begin
         if (out_valid && out_ready) begin
            out_valid <= 1'b0;
         end
         if (fifo_pop) begin
            if (emit) begin
               out_valid <= 1'b1;
               out_word  <= word_fmt;
               out_bytes <= CNT_W'(lane_sel) + CNT_W'(1);
               out_last  <= fifo_last;
               acc_q     <= '0;
               lane_q    <= '0;
               start_q   <= fifo_last;
            end else begin
               acc_q     <= acc_nxt;
               lane_q    <= lane_sel + 1'b1;
               start_q   <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/rxdma_packer.sv
`timescale 1ns/1ps
module rxdma_packer
   import rxdma_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 12,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_wr,
   input  logic [CFG_W-1:0]               cfg_wdata,
   output logic [CFG_W-1:0]               cfg_rdata,
   input  logic                           own_chk,
   input  logic                           own_by_dma,
   input  logic                           fifo_empty,
   input  logic [7:0]                     fifo_byte,
   input  logic                           fifo_last,
   output logic                           fifo_pop,
   output logic                           mem_valid,
   input  logic                           mem_ready,
   output logic [DATA_W-1:0]              mem_data,
   output logic [$clog2(DATA_W/8+1)-1:0]  mem_bytes,
   output logic                           mem_last,
   output logic [IDX_W-1:0]               desc_idx
);
   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = $clog2(LANES);

   generate
      if (DATA_W % 8 != 0 || LANES < 2 || (1 << LANE_W) != LANES) begin : g_bad_width
         $error("rxdma_packer: DATA_W must be a power-of-two number of bytes");
      end
      if (LANE_W != PAD_W) begin : g_bad_pad
         $error("rxdma_packer: pad field width does not match lane count");
      end
   endgenerate

   rx_cfg_t cfg;
   logic    clr_active, xfer_en, frame_done;

   rxdma_ctrl_reg #(.SWAP_EN(SWAP_EN)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_wr),
      .wdata      (cfg_wdata),
      .own_fail   (own_chk && !own_by_dma),
      .fifo_empty (fifo_empty),
      .cfg        (cfg),
      .clr_active (clr_active),
      .xfer_en    (xfer_en),
      .rdata      (cfg_rdata)
   );

   rxdma_byte_packer #(.BYTE_W(8), .LANES(LANES), .SWAP_EN(SWAP_EN)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_clr   (clr_active),
      .xfer_en    (xfer_en),
      .pad        (LANE_W'(cfg.pad)),
      .swap       (cfg.swap),
      .fifo_empty (fifo_empty),
      .fifo_byte  (fifo_byte),
      .fifo_last  (fifo_last),
      .fifo_pop   (fifo_pop),
      .frame_done (frame_done),
      .out_valid  (mem_valid),
      .out_ready  (mem_ready),
      .out_word   (mem_data),
      .out_bytes  (mem_bytes),
      .out_last   (mem_last)
   );

   rxdma_ring_index #(.IDX_W(IDX_W), .CODE_W(RING_CODE_W)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (clr_active),
      .code     (cfg.ring_code),
      .advance  (frame_done),
      .idx      (desc_idx)
   );
endmodule

// File: rtl/rxdma_packer_chk.sv
`timescale 1ns/1ps
module rxdma_packer_chk
   import rxdma_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 12
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [CFG_W-1:0]              cfg_rdata,
   input logic                          own_chk,
   input logic                          own_by_dma,
   input logic                          fifo_empty,
   input logic                          fifo_last,
   input logic                          fifo_pop,
   input logic                          mem_valid,
   input logic                          mem_ready,
   input logic [DATA_W-1:0]             mem_data,
   input logic [$clog2(DATA_W/8+1)-1:0] mem_bytes,
   input logic                          mem_last,
   input logic [IDX_W-1:0]              desc_idx
);
   localparam int LANES = DATA_W / 8;

   a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready && !cfg_rdata[CLR_BIT]) |=>
      (mem_valid && $stable(mem_data) && $stable(mem_bytes) && $stable(mem_last)))
      else $error("a_r10_hold_stalled");

   a_r10_no_pop_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |-> !fifo_pop)
      else $error("a_r10_no_pop_stalled");

   a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty)
      else $error("a_r6_no_pop_empty");

   a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_bytes >= 1 && int'(mem_bytes) <= LANES))
      else $error("a_r4_count_range");

   a_r7_own_drops_run: assert property (@(posedge clk) disable iff (!rst_n)
      (own_chk && !own_by_dma) |=> !cfg_rdata[RUN_BIT])
      else $error("a_r7_own_drops_run");

   a_r9_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[CLR_BIT] |=> (cfg_rdata == '0 && !mem_valid && desc_idx == '0))
      else $error("a_r9_clear_effect");

   a_r1_idx_only_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      (!(fifo_pop && fifo_last) && !cfg_rdata[CLR_BIT]) |=> $stable(desc_idx))
      else $error("a_r1_idx_only_on_end");
endmodule

bind rxdma_packer rxdma_packer_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_rdata  (cfg_rdata),
   .own_chk    (own_chk),
   .own_by_dma (own_by_dma),
   .fifo_empty (fifo_empty),
   .fifo_last  (fifo_last),
   .fifo_pop   (fifo_pop),
   .mem_valid  (mem_valid),
   .mem_ready  (mem_ready),
   .mem_data   (mem_data),
   .mem_bytes  (mem_bytes),
   .mem_last   (mem_last),
   .desc_idx   (desc_idx)
);

// File: tb/rxdma_packer_bench.sv
`timescale 1ns/1ps
module rxdma_packer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        own_chk = 1'b0, own_by_dma = 1'b1;
   logic        fifo_empty = 1'b1, fifo_last = 1'b0;
   logic [7:0]  fifo_byte = '0;
   logic        fifo_pop, mem_valid, mem_last;
   logic        mem_ready = 1'b1;
   logic [31:0] mem_data;
   logic [2:0]  mem_bytes;
   logic [11:0] desc_idx;

   always #2 clk = ~clk;

   rxdma_packer u_rxdma_packer (.*);

   logic [8:0]  fq[$];
   logic [31:0] exp_data[$];
   logic [2:0]  exp_bytes[$];
   logic        exp_last[$];
   int checks = 0, fails = 0, pops = 0;
   logic        ready_rand = 1'b0, ready_hold = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   logic [3:0]  cur_code = '0;
   int          idx_exp = 0;

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic refresh();
      fifo_empty = (fq.size() == 0);
      if (fq.size() != 0) {fifo_last, fifo_byte} = fq[0];
      else {fifo_last, fifo_byte} = 9'h0;
   endtask

   function automatic int ring_mask(logic [3:0] c);
      return (c >= 4'd12) ? 4095 : ((1 << c) - 1);
   endfunction

   function automatic logic [31:0] cfgw(int code, int pad, bit swp, bit run);
      return 32'(code) | (32'(pad) << 4) | (32'(swp) << 8) | (32'(run) << 12);
   endfunction

   // driver: pushes bytes into the FIFO model and expected words into the scoreboard
   task automatic send_frame(int len, int pad, bit swp, logic [7:0] seed);
      logic [31:0] w = '0;
      int lane = pad;
      for (int i = 0; i < len; i++) begin
         logic [7:0] b;
         bit last;
         b    = seed + 8'(i * 29);
         last = (i == len - 1);
         fq.push_back({last, b});
         w[lane*8 +: 8] = b;
         if (lane == 3 || last) begin
            exp_data.push_back(swp ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w);
            exp_bytes.push_back(3'(lane + 1));
            exp_last.push_back(last);
            w = '0;
            lane = 0;
         end else begin
            lane++;
         end
      end
      idx_exp = (idx_exp + 1) & ring_mask(cur_code);
      refresh();
   endtask

   task automatic wr_cfg(logic [31:0] v);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
      cur_code = v[3:0];
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (fq.size() == 0 && exp_data.size() == 0 && !mem_valid) break;
      end
      @(negedge clk);
   endtask

   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready <= ready_hold ? 1'b0 : (ready_rand ? lfsr[0] : 1'b1);
   end

   // monitor: compares accepted words and applies pops after the edge
   always begin : mon
      logic p, t, l;
      logic [31:0] d;
      logic [2:0] b;
      @(negedge clk);
      #1;
      p = fifo_pop;
      t = mem_valid && mem_ready;
      d = mem_data; b = mem_bytes; l = mem_last;
      if (t) begin
         if (exp_data.size() == 0) begin
            check(1'b0, "R3", "unexpected word", d, 32'h0);
         end else begin
            logic [31:0] ed;
            logic [2:0] eb;
            logic el;
            ed = exp_data.pop_front();
            eb = exp_bytes.pop_front();
            el = exp_last.pop_front();
            check(d == ed, "R2/R3/R5", "word data", d, ed);
            check(b == eb && l == el, "R4", "count/last", {28'h0, l, b}, {28'h0, el, eb});
         end
      end
      @(posedge clk);
      #1;
      if (p && fq.size() != 0) begin
         void'(fq.pop_front());
         pops++;
         refresh();
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      int p0;
      logic [31:0] d0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check(cfg_rdata == 0 && !mem_valid && desc_idx == 0 && !fifo_pop, "R9", "reset state",
            cfg_rdata, 32'h0);

      // R11 / R12 field layout
      wr_cfg(32'hFFFE_FFFF);
      check(cfg_rdata == 32'h0000_113F, "R11", "reserved bits read zero", cfg_rdata, 32'h0000_113F);
      wr_cfg(32'h0);
      repeat (3) @(negedge clk);

      // R6 no pop while stopped
      wr_cfg(cfgw(2, 1, 0, 0));
      p0 = pops;
      send_frame(6, 1, 0, 8'h10);
      repeat (10) @(negedge clk);
      check(pops == p0 && !mem_valid, "R6", "pops while run=0", 32'(pops - p0), 32'h0);
      wr_cfg(cfgw(2, 1, 0, 1));
      wait_idle();
      check(desc_idx == 12'(idx_exp), "R1", "index after frame", 32'(desc_idx), 32'(idx_exp));

      // R2 R3 R4 R5 pad and swap sweep
      for (int s = 0; s < 2; s++) begin
         for (int pd = 0; pd < 4; pd++) begin
            wr_cfg(cfgw(2, pd, s[0], 1));
            send_frame(1, pd, s[0], 8'(8'h21 + pd));
            send_frame(4, pd, s[0], 8'(8'h40 + pd));
            send_frame(7 + pd, pd, s[0], 8'(8'h77 + s));
            wait_idle();
            check(desc_idx == 12'(idx_exp), "R1", "ring of 4 wrap", 32'(desc_idx), 32'(idx_exp));
         end
      end

      // R10 random back-pressure then a held stall
      ready_rand = 1'b1;
      wr_cfg(cfgw(2, 2, 1, 1));
      send_frame(11, 2, 1, 8'h5A);
      send_frame(3, 2, 1, 8'hC3);
      wait_idle();
      ready_rand = 1'b0;
      wr_cfg(cfgw(2, 0, 0, 1));
      ready_hold = 1'b1;
      repeat (2) @(negedge clk);
      p0 = pops;
      send_frame(8, 0, 0, 8'h90);
      repeat (6) @(negedge clk);
      d0 = mem_data;
      check(mem_valid && pops - p0 == 4, "R10", "pops while stalled", 32'(pops - p0), 32'h4);
      repeat (5) @(negedge clk);
      check(mem_valid && mem_data == d0 && pops - p0 == 4, "R10", "word held", mem_data, d0);
      ready_hold = 1'b0;
      wait_idle();

      // R1 ring sizes
      wr_cfg(cfgw(0, 0, 0, 1));
      send_frame(2, 0, 0, 8'h01);
      send_frame(5, 0, 0, 8'h02);
      wait_idle();
      check(desc_idx == 0 && idx_exp == 0, "R1", "ring of 1", 32'(desc_idx), 32'h0);
      wr_cfg(cfgw(13, 0, 0, 1));
      for (int k = 0; k < 3; k++) send_frame(2, 0, 0, 8'(k));
      wait_idle();
      check(desc_idx == 12'(idx_exp), "R1", "ring of 4096", 32'(desc_idx), 32'(idx_exp));
      wr_cfg(cfgw(1, 0, 0, 1));
      send_frame(3, 0, 0, 8'hE0);
      wait_idle();
      check(desc_idx == 12'(idx_exp), "R1", "ring of 2 wrap", 32'(desc_idx), 32'(idx_exp));

      // R7 R8 ownership loss and drain
      wr_cfg(cfgw(3, 1, 0, 1));
      @(negedge clk);
      own_chk = 1'b1; own_by_dma = 1'b1;
      @(negedge clk);
      own_chk = 1'b0;
      check(cfg_rdata[12] == 1'b1, "R7", "owned keeps run", 32'(cfg_rdata[12]), 32'h1);
      ready_hold = 1'b1;
      repeat (2) @(negedge clk);
      send_frame(9, 1, 0, 8'h31);
      send_frame(5, 1, 0, 8'h62);
      repeat (4) @(negedge clk);
      own_chk = 1'b1; own_by_dma = 1'b0;
      @(negedge clk);
      own_chk = 1'b0; own_by_dma = 1'b1;
      check(cfg_rdata[12] == 1'b0, "R7", "run cleared", 32'(cfg_rdata[12]), 32'h0);
      ready_hold = 1'b0;
      wait_idle();
      check(fq.size() == 0, "R8", "backlog drained", 32'(fq.size()), 32'h0);
      p0 = pops;
      send_frame(4, 1, 0, 8'hA5);
      repeat (20) @(negedge clk);
      check(pops == p0 && fq.size() == 4, "R8", "no pop after drain", 32'(pops - p0), 32'h0);
      wr_cfg(cfgw(3, 1, 0, 1));
      wait_idle();
      check(exp_data.size() == 0 && desc_idx == 12'(idx_exp), "R8", "resume after enable",
            32'(desc_idx), 32'(idx_exp));

      // R9 clear with a partial word inside
      wr_cfg(cfgw(5, 0, 0, 1));
      fq.push_back({1'b0, 8'hDE});
      fq.push_back({1'b0, 8'hAD});
      refresh();
      repeat (6) @(negedge clk);
      wr_cfg(cfgw(5, 2, 1, 1) | 32'h0001_0000);
      check(cfg_rdata[16] == 1'b1, "R9", "clear bit visible", cfg_rdata, 32'h0001_0000);
      @(negedge clk);
      check(cfg_rdata == 0 && desc_idx == 0 && !mem_valid, "R9", "cleared state", cfg_rdata, 32'h0);
      idx_exp = 0;
      wr_cfg(cfgw(2, 3, 0, 1));
      send_frame(5, 3, 0, 8'h11);
      wait_idle();
      check(desc_idx == 12'(idx_exp), "R9", "fresh frame after clear", 32'(desc_idx), 32'(idx_exp));

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule